// File: doc/BRIEF.md
# Receive Frame Status Filter

This block sits on the receive path between a gigabit MAC and a downstream packet consumer. Each incoming frame, jumbo frames included, is written whole into a local synchronous buffer memory. The frame's fate is decided only when the MAC sends a status word. That word arrives after the last data beat. If the word carries no error flag, the frame is committed and later replayed downstream with start and end markers under a ready/valid handshake. If the word carries an error flag, the write pointer returns to the frame's first address and the space is free at once.

The MAC cannot be stalled. If the buffer runs out of room in mid-frame, or if no descriptor slot is free when a good status arrives, the frame is also dropped. Every dropped frame advances a wrapping counter. Committed frames lie back to back in the buffer in arrival order. Each descriptor therefore holds only a length, and the read side drains frames in that same order.

Top module: `rx_status_filter`

## Requirements
- R1: After reset, out_valid is 0 and drop_cnt is 0.
- R2: No beat of a frame is presented downstream before its status word is accepted. With the output idle, out_valid stays 0 in the cycle after the status cycle and rises in the cycle after that for a committed frame.
- R3: stat_word bit 0 (CRC error) and bit 1 (length/overrun error) each cause the frame to be discarded. Bits above 1 have no effect. A discarded frame produces no downstream beat.
- R4: A committed frame is replayed complete, with its beats in order and frames in arrival order. out_sof marks the first beat and out_eof marks the last beat; a one-beat frame carries both.
- R5: While out_valid is 1 and out_ready is 0, out_valid, out_data, out_sof and out_eof hold their values, and no beat is lost.
- R6: The buffer space of a discarded frame is reusable immediately: the next frame is stored from the discarded frame's first address.
- R7: When the buffer has no free word for a beat, the rest of that frame is not stored and the frame is dropped at its status. A frame of exactly the free space is kept, and a frame longer than the whole buffer is always dropped.
- R8: A frame whose good status arrives while the descriptor queue is full is dropped.
- R9: drop_cnt increases by exactly one in the cycle after the status of each dropped frame and is otherwise unchanged.
- R10: A stat_valid pulse before a frame's last beat is ignored. Data beats that arrive after the last beat and before the status are also ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Receive data beat valid |
| in_data | input | DW | Receive data beat |
| in_last | input | 1 | Marks the last data beat of a frame, qualified by in_valid |
| stat_valid | input | 1 | Frame status word valid (after the last beat) |
| stat_word | input | SW | Frame status; bit 0 CRC error, bit 1 length/overrun error |
| out_valid | output | 1 | Downstream beat valid |
| out_data | output | DW | Downstream beat |
| out_sof | output | 1 | First beat of a frame |
| out_eof | output | 1 | Last beat of a frame |
| out_ready | input | 1 | Downstream accepts the beat |
| drop_cnt | output | CNTW | Wrapping count of dropped frames |

## Verification
The bench builds the block with DW=8, AW=4 (a 16-word buffer), SW=4, DESC_DEPTH=4 and CNTW=8. This makes a frame of every length from 1 to the full buffer practical, each combined with all sixteen status values under a stalling ready pattern. The small buffer and queue also make mid-frame overflow, an exact-fit frame, reuse of rolled-back space, an oversize frame and a full descriptor queue reachable with a few short frames. Under these conditions the bench checks the exact cycle in which the first beat appears.

// File: rtl/rxsf_pkg.sv
package rxsf_pkg;
  typedef enum logic {
    WR_RECV = 1'b0,
    WR_WAIT = 1'b1
  } wr_state_e;

  localparam int unsigned ST_CRC_BIT = 0;
  localparam int unsigned ST_LEN_BIT = 1;
endpackage

// File: rtl/rxsf_ram.sv
module rxsf_ram #(
  parameter int unsigned DW = 64,
  parameter int unsigned AW = 11
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/rxsf_wr_ctrl.sv
module rxsf_wr_ctrl
  import rxsf_pkg::*;
#(
  parameter int unsigned AW   = 11,
  parameter int unsigned SW   = 4,
  parameter int unsigned CNTW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_last,
  input  logic          stat_valid,
  input  logic [SW-1:0] stat_word,
  input  logic [AW:0]   rd_ptr,
  input  logic          desc_full,
  output logic          ram_we,
  output logic [AW-1:0] ram_waddr,
  output logic          push,
  output logic [AW:0]   push_len,
  output logic [CNTW-1:0] drop_cnt
);
  localparam int unsigned PW = AW + 1;
  localparam logic [PW-1:0]   P_ONE = {{(PW-1){1'b0}}, 1'b1};
  localparam logic [CNTW-1:0] C_ONE = {{(CNTW-1){1'b0}}, 1'b1};

  wr_state_e state_q, state_d;
  logic [PW-1:0] wr_q, wr_d, start_q, start_d, len_q, len_d;
  logic          trunc_q, trunc_d;
  logic [CNTW-1:0] drop_q, drop_d;
  logic [PW-1:0] used;
  logic          full, st_err, reject;

  always_comb begin
    used    = wr_q - rd_ptr;
    full    = used[AW];
    st_err  = stat_word[ST_CRC_BIT] | stat_word[ST_LEN_BIT];
    reject  = st_err | trunc_q | desc_full;
    state_d = state_q;
    wr_d    = wr_q;
    start_d = start_q;
    len_d   = len_q;
    trunc_d = trunc_q;
    drop_d  = drop_q;
    ram_we  = 1'b0;
    push    = 1'b0;
    case (state_q)
      WR_RECV: begin
        if (in_valid) begin
          if (!full && !trunc_q) begin
            ram_we = 1'b1;
            wr_d   = wr_q + P_ONE;
            len_d  = len_q + P_ONE;
          end else begin
            trunc_d = 1'b1;
          end
          if (in_last) state_d = WR_WAIT;
        end
      end
      WR_WAIT: begin
        if (stat_valid) begin
          if (reject) begin
            wr_d   = start_q;
            drop_d = drop_q + C_ONE;
          end else begin
            push    = 1'b1;
            start_d = wr_q;
          end
          len_d   = '0;
          trunc_d = 1'b0;
          state_d = WR_RECV;
        end
      end
      default: state_d = WR_RECV;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WR_RECV;
      wr_q    <= '0;
      start_q <= '0;
      len_q   <= '0;
      trunc_q <= 1'b0;
      drop_q  <= '0;
    end else begin
      state_q <= state_d;
      wr_q    <= wr_d;
      start_q <= start_d;
      len_q   <= len_d;
      trunc_q <= trunc_d;
      drop_q  <= drop_d;
    end
  end

  assign ram_waddr = wr_q[AW-1:0];
  assign push_len  = len_q;
  assign drop_cnt  = drop_q;
endmodule

// File: rtl/rxsf_desc_fifo.sv
module rxsf_desc_fifo #(
  parameter int unsigned W     = 12,
  parameter int unsigned DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int unsigned PW = $clog2(DEPTH);
  localparam logic [PW-1:0] I_ONE = {{(PW-1){1'b0}}, 1'b1};
  localparam logic [PW:0]   N_ONE = {{PW{1'b0}}, 1'b1};

  logic [W-1:0] mem [DEPTH];
  logic [PW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [PW:0]   cnt_q, cnt_d;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (push) wp_d = wp_q + I_ONE;
    if (pop)  rp_d = rp_q + I_ONE;
    case ({push, pop})
      2'b10:   cnt_d = cnt_q + N_ONE;
      2'b01:   cnt_d = cnt_q - N_ONE;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp_q] <= wdata;
  end

  assign rdata = mem[rp_q];
  assign empty = (cnt_q == '0);
  assign full  = cnt_q[PW];
endmodule

// File: rtl/rxsf_rd_ctrl.sv
module rxsf_rd_ctrl #(
  parameter int unsigned AW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          desc_empty,
  input  logic [AW:0]   head_len,
  output logic          desc_pop,
  input  logic          out_ready,
  output logic          ram_re,
  output logic [AW-1:0] ram_raddr,
  output logic [AW:0]   rd_ptr,
  output logic          out_valid,
  output logic          out_sof,
  output logic          out_eof
);
  localparam int unsigned PW = AW + 1;
  localparam logic [PW-1:0] P_ONE = {{(PW-1){1'b0}}, 1'b1};

  logic [PW-1:0] rd_q, rd_d, rem_q, rem_d, len_eff;
  logic          v_q, v_d, sof_q, sof_d, eof_q, eof_d;
  logic          load, cont, act;

  always_comb begin
    load     = !v_q || out_ready;
    cont     = (rem_q != '0);
    act      = load && (cont || !desc_empty);
    desc_pop = load && !cont && !desc_empty;
    len_eff  = cont ? rem_q : head_len;
    rd_d     = rd_q;
    rem_d    = rem_q;
    v_d      = v_q;
    sof_d    = sof_q;
    eof_d    = eof_q;
    if (act) begin
      rd_d  = rd_q + P_ONE;
      rem_d = len_eff - P_ONE;
      v_d   = 1'b1;
      sof_d = !cont;
      eof_d = (len_eff == P_ONE);
    end else if (load) begin
      v_d   = 1'b0;
      sof_d = 1'b0;
      eof_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      rem_q <= '0;
      v_q   <= 1'b0;
      sof_q <= 1'b0;
      eof_q <= 1'b0;
    end else begin
      rd_q  <= rd_d;
      rem_q <= rem_d;
      v_q   <= v_d;
      sof_q <= sof_d;
      eof_q <= eof_d;
    end
  end

  assign ram_re    = act;
  assign ram_raddr = rd_q[AW-1:0];
  assign rd_ptr    = rd_q;
  assign out_valid = v_q;
  assign out_sof   = sof_q;
  assign out_eof   = eof_q;
endmodule

// File: rtl/rx_status_filter.sv
module rx_status_filter #(
  parameter int unsigned DW         = 64,
  parameter int unsigned AW         = 11,
  parameter int unsigned SW         = 4,
  parameter int unsigned DESC_DEPTH = 8,
  parameter int unsigned CNTW       = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [DW-1:0]   in_data,
  input  logic            in_last,
  input  logic            stat_valid,
  input  logic [SW-1:0]   stat_word,
  output logic            out_valid,
  output logic [DW-1:0]   out_data,
  output logic            out_sof,
  output logic            out_eof,
  input  logic            out_ready,
  output logic [CNTW-1:0] drop_cnt
);
  localparam int unsigned LW = AW + 1;

  logic [1:0]    rst_sync;
  logic          rst_int_n;
  logic          ram_we, ram_re, push, pop, d_empty, d_full;
  logic [AW-1:0] waddr, raddr;
  logic [LW-1:0] push_len, head_len, rd_ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  rxsf_wr_ctrl #(.AW(AW), .SW(SW), .CNTW(CNTW)) u_wr (
    .clk(clk), .rst_n(rst_int_n), .in_valid(in_valid), .in_last(in_last),
    .stat_valid(stat_valid), .stat_word(stat_word), .rd_ptr(rd_ptr),
    .desc_full(d_full), .ram_we(ram_we), .ram_waddr(waddr), .push(push),
    .push_len(push_len), .drop_cnt(drop_cnt)
  );

  rxsf_desc_fifo #(.W(LW), .DEPTH(DESC_DEPTH)) u_desc (
    .clk(clk), .rst_n(rst_int_n), .push(push), .wdata(push_len), .pop(pop),
    .rdata(head_len), .empty(d_empty), .full(d_full)
  );

  rxsf_ram #(.DW(DW), .AW(AW)) u_ram (
    .clk(clk), .we(ram_we), .waddr(waddr), .wdata(in_data), .re(ram_re),
    .raddr(raddr), .rdata(out_data)
  );

  rxsf_rd_ctrl #(.AW(AW)) u_rd (
    .clk(clk), .rst_n(rst_int_n), .desc_empty(d_empty), .head_len(head_len),
    .desc_pop(pop), .out_ready(out_ready), .ram_re(ram_re), .ram_raddr(raddr),
    .rd_ptr(rd_ptr), .out_valid(out_valid), .out_sof(out_sof), .out_eof(out_eof)
  );
endmodule

// File: rtl/rxsf_chk.sv
module rxsf_chk #(
  parameter int unsigned DW   = 64,
  parameter int unsigned CNTW = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            stat_valid,
  input logic            out_valid,
  input logic            out_ready,
  input logic            out_sof,
  input logic            out_eof,
  input logic [DW-1:0]   out_data,
  input logic [CNTW-1:0] drop_cnt
);
  logic in_frame_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      in_frame_q <= 1'b0;
    else if (out_valid && out_ready) in_frame_q <= !out_eof;
  end

  AST_HOLD_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_sof) && $stable(out_eof))); // R5
  AST_SOF_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !in_frame_q) |-> out_sof); // R4
  AST_SOF_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && in_frame_q) |-> !out_sof); // R4
  AST_DROP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_valid |=> $stable(drop_cnt)); // R9
  AST_DROP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |=> (drop_cnt == $past(drop_cnt) || drop_cnt == $past(drop_cnt) + 1'b1)); // R9
endmodule

bind rx_status_filter rxsf_chk #(.DW(DW), .CNTW(CNTW)) u_chk (
  .clk(clk), .rst_n(rst_n), .stat_valid(stat_valid), .out_valid(out_valid),
  .out_ready(out_ready), .out_sof(out_sof), .out_eof(out_eof),
  .out_data(out_data), .drop_cnt(drop_cnt)
);

// File: tb/rx_status_filter_bench.sv
`timescale 1ns/1ps
module rx_status_filter_bench;
  localparam int DW = 8, AW = 4, SW = 4, DD = 4, CNTW = 8;

  logic clk, rst_n, in_valid, in_last, stat_valid, out_ready;
  logic [DW-1:0] in_data, out_data;
  logic [SW-1:0] stat_word;
  logic out_valid, out_sof, out_eof;
  logic [CNTW-1:0] drop_cnt;

  int nchk = 0, nfail = 0, exp_drop = 0, cyc = 0, rmode = 0;
  bit done = 0;
  logic [9:0] exp_q[$];
  logic [9:0] e, hold_val;
  bit hold_pend = 0;

  rx_status_filter #(.DW(DW), .AW(AW), .SW(SW), .DESC_DEPTH(DD), .CNTW(CNTW)) u_rx_status_filter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .stat_valid(stat_valid), .stat_word(stat_word), .out_valid(out_valid), .out_data(out_data),
    .out_sof(out_sof), .out_eof(out_eof), .out_ready(out_ready), .drop_cnt(drop_cnt)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge clk) begin
    #1;
    case (rmode)
      0: out_ready = 1'b1;
      1: out_ready = 1'b0;
      default: out_ready = ((cyc % 3) != 0);
    endcase
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, expv);
    end
  endtask

  function automatic logic [7:0] dat(input int fid, input int b);
    return 8'((fid * 37 + b * 5 + 3) % 256);
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_pend)
        chk(out_valid && ({out_sof, out_eof, out_data} == hold_val), "R5 beat held under stall",
            {23'd0, out_valid, out_sof, out_eof, out_data}, {23'd1, hold_val});
      hold_pend = out_valid && !out_ready;
      hold_val  = {out_sof, out_eof, out_data};
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R4 unexpected beat", {22'd0, out_sof, out_eof, out_data}, 32'hFFFF);
        end else begin
          e = exp_q.pop_front();
          chk({out_sof, out_eof, out_data} == e, "R4 beat content/markers",
              {22'd0, out_sof, out_eof, out_data}, {22'd0, e});
        end
      end
    end
  end

  task automatic push_exp(input int fid, input int len);
    for (int b = 0; b < len; b++)
      exp_q.push_back({b == 0, b == len - 1, dat(fid, b)});
  endtask

  task automatic send_frame(input int fid, input int len, input int st, input bit good, input bit lat);
    if (good) push_exp(fid, len); else exp_drop++;
    for (int b = 0; b < len; b++) begin
      @(posedge clk); #1;
      in_valid = 1'b1; in_data = dat(fid, b); in_last = (b == len - 1);
    end
    @(posedge clk); #1;
    in_valid = 1'b0; in_last = 1'b0;
    repeat (2) @(posedge clk);
    #1; stat_valid = 1'b1; stat_word = st[SW-1:0];
    @(posedge clk); #1;
    stat_valid = 1'b0;
    chk(drop_cnt == CNTW'(exp_drop), "R9 drop count after status", drop_cnt, exp_drop);
    if (lat) begin
      @(negedge clk);
      chk(!out_valid, "R2 no beat before commit", out_valid, 0);
      @(negedge clk);
      chk(out_valid == good, "R2/R3 first beat timing", out_valid, good);
    end
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(posedge clk);
    repeat (3) @(posedge clk);
  endtask

  task automatic beat(input logic [7:0] d, input bit last);
    @(posedge clk); #1;
    in_valid = 1'b1; in_data = d; in_last = last;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired act=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; in_valid = 0; in_last = 0; in_data = 0; stat_valid = 0; stat_word = 0; out_ready = 1;
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(!out_valid, "R1 out_valid after reset", out_valid, 0);
    chk(drop_cnt == 0, "R1 drop_cnt after reset", drop_cnt, 0);

    // R3 R4 R2: sweep every length up to the buffer size with every status value
    rmode = 2;
    for (int len = 1; len <= 16; len++)
      for (int st = 0; st < 16; st++) begin
        send_frame(len * 16 + st, len, st, (st & 3) == 0, 1'b1);
        drain();
      end

    // R7: frame longer than the buffer is dropped; an exact fit is kept
    rmode = 0;
    send_frame(500, 17, 0, 1'b0, 1'b1);
    drain();
    send_frame(501, 16, 0, 1'b1, 1'b1);
    drain();

    // R10: early status pulse and late data beat are ignored
    push_exp(900, 4);
    beat(dat(900, 0), 0);
    beat(dat(900, 1), 0);
    @(posedge clk); #1; in_valid = 0; stat_valid = 1; stat_word = 4'h1;
    @(posedge clk); #1; stat_valid = 0;
    beat(dat(900, 2), 0);
    beat(dat(900, 3), 1);
    beat(8'hEE, 1);
    @(posedge clk); #1; in_valid = 0; in_last = 0;
    @(posedge clk); #1; stat_valid = 1; stat_word = 4'h0;
    @(posedge clk); #1; stat_valid = 0;
    drain();
    chk(drop_cnt == CNTW'(exp_drop), "R10 stray status did not drop", drop_cnt, exp_drop);
    chk(exp_q.size() == 0, "R10 frame delivered intact", exp_q.size(), 0);

    // R6 R7: overflow in mid-frame, rollback, reuse of the space
    rmode = 1;
    repeat (3) @(posedge clk);
    send_frame(600, 10, 0, 1'b1, 1'b0);
    repeat (5) @(posedge clk);
    send_frame(601, 8, 0, 1'b0, 1'b0);
    send_frame(602, 7, 0, 1'b1, 1'b0);
    send_frame(603, 1, 0, 1'b0, 1'b0);
    rmode = 0;
    drain();
    chk(exp_q.size() == 0, "R6 reused space frame delivered", exp_q.size(), 0);

    // R8: descriptor queue full
    rmode = 1;
    repeat (3) @(posedge clk);
    for (int f = 0; f < 5; f++) begin
      send_frame(700 + f, 2, 0, 1'b1, 1'b0);
      repeat (3) @(posedge clk);
    end
    send_frame(705, 2, 0, 1'b0, 1'b0);
    chk(drop_cnt == CNTW'(exp_drop), "R8 drop on full queue", drop_cnt, exp_drop);
    rmode = 0;
    drain();

    chk(exp_q.size() == 0, "R4 all frames delivered", exp_q.size(), 0);
    chk(drop_cnt == CNTW'(exp_drop), "R9 final drop count", drop_cnt, exp_drop);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule